// File: doc/BRIEF.md
# Double-Buffered Color Matrix Converter

This block converts a stream of three-channel pixels (RGB or YCbCr) with a 3x3 signed coefficient matrix plus one additive offset per output row. Each output channel is the weighted sum of the three input channels plus that row's offset. The result is rounded to nearest and clamped to the unsigned pixel range. A bypass setting passes pixels through untouched.

Two full coefficient sets are held on chip. Software reads which set is in use, rewrites the other one through a small write port, and then requests it. The request is held as pending and is applied only on the pixel that carries the frame-start strobe. A frame is therefore always converted with a single, consistent matrix, and successive updates alternate between the two sets.

The pipeline has a fixed depth of three clock cycles. The valid and frame-start strobes travel through it alongside the data.

Top module: `cmx_convert`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` and `out_sof` are 0, `out_data` is 0, `active_bank` is 0 (bypass), and both coefficient sets are all zero.
- R2: While the applied mode is 0 (bypass), each output channel equals the corresponding input channel.
- R3: `out_valid` equals `pix_valid` from exactly 3 cycles earlier. `out_sof` equals `pix_valid && pix_sof` from 3 cycles earlier. `out_sof` is never high without `out_valid`.
- R4: Channel k of a pixel occupies bits [k*PIX_W +: PIX_W], with channel 0 in the low bits. Coefficients are signed 16-bit two's complement with 13 fraction bits, so 0x2000 is a gain of 1. Output row r is (Cr1*x0 + Cr2*x1 + Cr3*x2 + Cr4*2^13) / 2^13. The fourth coefficient of a row is therefore an offset in whole pixel steps.
- R5: The division by 2^13 rounds to nearest, with exact halves rounded upward (add 2^12, then floor).
- R6: A result below 0 gives 0, and a result above 2^PIX_W-1 gives 2^PIX_W-1.
- R7: Coefficient writes use `cfg_addr[3]` to pick the set (0 is set A, 1 is set B) and `cfg_addr[2:0]` to pick pair p, for p from 0 to 5. Pair p carries row-order coefficient 2p in `cfg_wdata[15:0]` and coefficient 2p+1 in `cfg_wdata[31:16]`. The row order is C11,C12,C13,C14,C21,...,C34. Writes to addresses 6, 7 and 14 change nothing.
- R8: A write to address 15 sets the pending mode from `cfg_wdata[1:0]`: 0 selects bypass, 1 selects set A and 2 selects set B. A value of 3 is ignored and leaves the pending mode unchanged.
- R9: The pending mode becomes the applied mode only on a pixel that has `pix_valid` and `pix_sof` both high. That pixel is already converted with the new mode. Pixels without the frame-start strobe keep the previous mode. `active_bank` reports the applied mode, not the pending one, and it changes only in the cycle after such a pixel.
- R10: With 0x2000 on the diagonal and every other coefficient 0, the output equals the input for any pixel value.
- R11: Rewriting the set that is not applied, and then requesting it, leaves the output unchanged until the next frame-start pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Input pixel is valid |
| pix_sof | input | 1 | Input pixel is the first of a frame |
| pix_data | input | 3*PIX_W | Input pixel, channel 0 in the low bits |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address (set and pair, or 15 for mode) |
| cfg_wdata | input | 2*COEF_W | Configuration write data |
| out_valid | output | 1 | Output pixel is valid |
| out_sof | output | 1 | Output pixel is the first of a frame |
| out_data | output | 3*PIX_W | Converted pixel |
| active_bank | output | 2 | Applied mode: 0 bypass, 1 set A, 2 set B |

## Verification
The bench builds the block with its defaults: 12-bit channels, 16-bit coefficients and 13 fraction bits. At 12 bits a unity-gain row with a small positive offset pushes pixels near 4095 past the top of the range. A gain of 2 overflows as well, and a negative offset drives low values below zero, so both clamps are exercised with ordinary inputs. A half-gain row that sums two channels lands exactly on .5 for odd sums, which exposes the round-half-up rule. Switching between the two sets with and without the frame-start strobe shows the pending and applied modes separating at the ports.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
  localparam int NUM_CH     = 3;             // channels per pixel
  localparam int NUM_COLS   = NUM_CH + 1;    // gains plus offset per row
  localparam int NUM_COEF   = NUM_CH * NUM_COLS;
  localparam int NUM_PAIR   = NUM_COEF / 2;
  localparam int NUM_BANKS  = 2;
  localparam int PAIR_IDX_W = $clog2(NUM_PAIR);
  localparam int ADDR_W     = PAIR_IDX_W + 1;
  localparam int LAT        = 3;

  localparam logic [ADDR_W-1:0] MODE_ADDR = '1;

  localparam logic [1:0] MODE_BYPASS = 2'd0;
  localparam logic [1:0] MODE_BANK_A = 2'd1;
  localparam logic [1:0] MODE_BANK_B = 2'd2;
  localparam logic [1:0] MODE_RSVD   = 2'd3;
endpackage

// File: rtl/cmx_coef_bank.sv
module cmx_coef_bank
  import cmx_pkg::*;
#(
  parameter int COEF_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [2*COEF_W-1:0]        wr_data,
  input  logic                       frame_take,
  output logic [1:0]                 mode_sel,
  output logic [1:0]                 act_mode,
  output logic [NUM_COEF*COEF_W-1:0] coef_sel
);
  localparam int PAIR_W = 2 * COEF_W;

  logic [PAIR_W-1:0]     store [NUM_BANKS][NUM_PAIR];
  logic [1:0]            pend_q;
  logic [1:0]            act_q;
  logic [PAIR_IDX_W-1:0] pidx;
  logic                  bank_bit;
  logic                  is_mode;
  logic                  pidx_ok;
  logic                  use_b;

  assign pidx     = wr_addr[PAIR_IDX_W-1:0];
  assign bank_bit = wr_addr[ADDR_W-1];
  assign is_mode  = (wr_addr == MODE_ADDR);
  assign pidx_ok  = (int'(pidx) < NUM_PAIR);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NUM_BANKS; b++)
        for (int p = 0; p < NUM_PAIR; p++)
          store[b][p] <= '0;
    end else if (wr_en && !is_mode && pidx_ok) begin
      store[bank_bit][pidx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= MODE_BYPASS;
      act_q  <= MODE_BYPASS;
    end else begin
      if (wr_en && is_mode && (wr_data[1:0] != MODE_RSVD))
        pend_q <= wr_data[1:0];
      if (frame_take)
        act_q <= pend_q;
    end
  end

  // The frame-start pixel itself already uses the pending selection.
  assign mode_sel = frame_take ? pend_q : act_q;
  assign act_mode = act_q;
  assign use_b    = (mode_sel == MODE_BANK_B);

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    assign coef_sel[p*PAIR_W +: PAIR_W] = use_b ? store[1][p] : store[0][p];
  end
endmodule

// File: rtl/cmx_row.sv
module cmx_row
  import cmx_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int COEF_W = 16,
  parameter int FRAC   = 13
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       byp_i,
  input  logic [PIX_W-1:0]           pass_i,
  input  logic [NUM_CH*PIX_W-1:0]    x_i,
  input  logic [NUM_COLS*COEF_W-1:0] coef_i,
  output logic [PIX_W-1:0]           y_o
);
  localparam int SUM_W = COEF_W + PIX_W + FRAC + 3;
  localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) <<< (FRAC - 1);
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << PIX_W) - 1);

  logic signed [SUM_W-1:0] prod_d [NUM_CH];
  logic signed [SUM_W-1:0] prod_q [NUM_CH];
  logic signed [SUM_W-1:0] off_d;
  logic signed [SUM_W-1:0] off_q;
  logic                    byp_q;
  logic [PIX_W-1:0]        pass_q;
  logic signed [SUM_W-1:0] acc;
  logic signed [SUM_W-1:0] scaled;
  logic [PIX_W-1:0]        sat;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_tap
    logic signed [SUM_W-1:0] cx;
    logic signed [SUM_W-1:0] xx;
    assign cx        = SUM_W'(signed'(coef_i[k*COEF_W +: COEF_W]));
    assign xx        = SUM_W'({1'b0, x_i[k*PIX_W +: PIX_W]});
    assign prod_d[k] = cx * xx;
  end

  assign off_d = SUM_W'(signed'(coef_i[NUM_CH*COEF_W +: COEF_W])) <<< FRAC;

  // stage A: products and offset
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_CH; k++) prod_q[k] <= '0;
      off_q  <= '0;
      byp_q  <= 1'b1;
      pass_q <= '0;
    end else begin
      for (int k = 0; k < NUM_CH; k++) prod_q[k] <= prod_d[k];
      off_q  <= off_d;
      byp_q  <= byp_i;
      pass_q <= pass_i;
    end
  end

  always_comb begin
    acc = off_q + HALF;
    for (int k = 0; k < NUM_CH; k++) acc = acc + prod_q[k];
    scaled = acc >>> FRAC;
  end

  always_comb begin
    if (scaled[SUM_W-1])    sat = '0;
    else if (scaled > MAXV) sat = '1;
    else                    sat = scaled[PIX_W-1:0];
  end

  // stage B: sum, round, clamp, registered output
  always_ff @(posedge clk) begin
    if (rst) y_o <= '0;
    else     y_o <= byp_q ? pass_q : sat;
  end
endmodule

// File: rtl/cmx_convert.sv
module cmx_convert
  import cmx_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int COEF_W = 16,
  parameter int FRAC   = 13
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pix_valid,
  input  logic                    pix_sof,
  input  logic [NUM_CH*PIX_W-1:0] pix_data,
  input  logic                    cfg_wr_en,
  input  logic [ADDR_W-1:0]       cfg_addr,
  input  logic [2*COEF_W-1:0]     cfg_wdata,
  output logic                    out_valid,
  output logic                    out_sof,
  output logic [NUM_CH*PIX_W-1:0] out_data,
  output logic [1:0]              active_bank
);
  localparam int SET_W = NUM_COEF * COEF_W;
  localparam int ROW_W = NUM_COLS * COEF_W;

  logic                    frame_take;
  logic [1:0]              mode_sel;
  logic [SET_W-1:0]        coef_sel;
  logic [SET_W-1:0]        coef_q;
  logic [NUM_CH*PIX_W-1:0] x_q;
  logic                    byp_q;
  logic [LAT-1:0]          v_pipe;
  logic [LAT-1:0]          sof_pipe;

  assign frame_take = pix_valid & pix_sof;

  cmx_coef_bank #(.COEF_W(COEF_W)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (cfg_wr_en),
    .wr_addr    (cfg_addr),
    .wr_data    (cfg_wdata),
    .frame_take (frame_take),
    .mode_sel   (mode_sel),
    .act_mode   (active_bank),
    .coef_sel   (coef_sel)
  );

  // stage 1: capture pixel together with the coefficient set it uses
  always_ff @(posedge clk) begin
    if (rst) begin
      x_q      <= '0;
      coef_q   <= '0;
      byp_q    <= 1'b1;
      v_pipe   <= '0;
      sof_pipe <= '0;
    end else begin
      x_q      <= pix_data;
      coef_q   <= coef_sel;
      byp_q    <= (mode_sel == MODE_BYPASS);
      v_pipe   <= {v_pipe[LAT-2:0], pix_valid};
      sof_pipe <= {sof_pipe[LAT-2:0], frame_take};
    end
  end

  for (genvar r = 0; r < NUM_CH; r++) begin : g_row
    cmx_row #(.PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC(FRAC)) u_row (
      .clk    (clk),
      .rst    (rst),
      .byp_i  (byp_q),
      .pass_i (x_q[r*PIX_W +: PIX_W]),
      .x_i    (x_q),
      .coef_i (coef_q[r*ROW_W +: ROW_W]),
      .y_o    (out_data[r*PIX_W +: PIX_W])
    );
  end

  assign out_valid = v_pipe[LAT-1];
  assign out_sof   = sof_pipe[LAT-1];
endmodule

// File: rtl/cmx_checks.sv
module cmx_checks (
  input logic       clk,
  input logic       rst,
  input logic       pix_valid,
  input logic       pix_sof,
  input logic       out_valid,
  input logic       out_sof,
  input logic [1:0] active_bank
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= '0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  p_valid_latency_r3: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3) |-> (out_valid == $past(pix_valid, 3)));

  p_sof_latency_r3: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3) |-> (out_sof == $past(pix_valid && pix_sof, 3)));

  p_sof_has_valid_r3: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid);

  p_status_legal_r8: assert property (@(posedge clk) disable iff (rst)
    active_bank != 2'd3);

  p_status_at_frame_r9: assert property (@(posedge clk) disable iff (rst)
    ((since_rst != 0) && !$stable(active_bank)) |-> $past(pix_valid && pix_sof));
endmodule

bind cmx_convert cmx_checks u_checks (
  .clk         (clk),
  .rst         (rst),
  .pix_valid   (pix_valid),
  .pix_sof     (pix_sof),
  .out_valid   (out_valid),
  .out_sof     (out_sof),
  .active_bank (active_bank)
);

// File: tb/tb_cmx_convert.sv
module tb_cmx_convert;
  localparam int P = 12;
  localparam int C = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pix_valid = 1'b0;
  logic          pix_sof = 1'b0;
  logic [3*P-1:0] pix_data = '0;
  logic          cfg_wr_en = 1'b0;
  logic [3:0]    cfg_addr = '0;
  logic [2*C-1:0] cfg_wdata = '0;
  logic          out_valid;
  logic          out_sof;
  logic [3*P-1:0] out_data;
  logic [1:0]    active_bank;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmx_convert #(.PIX_W(P), .COEF_W(C), .FRAC(13)) dut (
    .clk, .rst, .pix_valid, .pix_sof, .pix_data, .cfg_wr_en, .cfg_addr,
    .cfg_wdata, .out_valid, .out_sof, .out_data, .active_bank
  );

  // x0, x1, x2, y0, y1, y2 under set A: y0=x0+16, y1=(x0+x1)/2, y2=4095-x2
  localparam int VEC [6][6] = '{
    '{0,    0,    0,    16,   0,    4095},
    '{100,  200,  300,  116,  150,  3795},
    '{1,    2,    3,    17,   2,    4092},
    '{4090, 4095, 4095, 4095, 4093, 0},
    '{4095, 0,    1,    4095, 2048, 4094},
    '{10,   11,   4000, 26,   11,   95}
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic prog(input bit bank, input logic [31:0] p0, p1, p2, p3, p4, p5);
    wr({bank, 3'd0}, p0); wr({bank, 3'd1}, p1); wr({bank, 3'd2}, p2);
    wr({bank, 3'd3}, p3); wr({bank, 3'd4}, p4); wr({bank, 3'd5}, p5);
  endtask

  task automatic run_pix(input int a, b, c, input bit sof,
                         input int ea, eb, ec, input string tag);
    @(negedge clk);
    pix_valid = 1'b1; pix_sof = sof;
    pix_data = {c[P-1:0], b[P-1:0], a[P-1:0]};
    @(negedge clk);
    pix_valid = 1'b0; pix_sof = 1'b0;
    @(negedge clk);
    chk("R3 valid not early", int'(out_valid), 0);
    @(negedge clk);
    chk("R3 valid after 3", int'(out_valid), 1);
    chk("R3 sof after 3", int'(out_sof), int'(sof));
    chk({tag, " ch0"}, int'(out_data[P-1:0]), ea);
    chk({tag, " ch1"}, int'(out_data[2*P-1:P]), eb);
    chk({tag, " ch2"}, int'(out_data[3*P-1:2*P]), ec);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset out_valid", int'(out_valid), 0);
    chk("R1 reset out_sof", int'(out_sof), 0);
    chk("R1 reset out_data", int'(out_data), 0);
    chk("R1 reset status", int'(active_bank), 0);

    // bypass straight out of reset
    run_pix(123, 456, 789, 1'b1, 123, 456, 789, "R2 bypass");

    // set A, then request it on a frame start
    prog(1'b0, 32'h0000_2000, 32'h0010_0000, 32'h1000_1000,
               32'h0000_0000, 32'h0000_0000, 32'h0FFF_E000);
    wr(4'hF, 32'd1);
    chk("R9 status holds before frame start", int'(active_bank), 0);
    for (int i = 0; i < 6; i++)
      run_pix(VEC[i][0], VEC[i][1], VEC[i][2], (i == 0),
              VEC[i][3], VEC[i][4], VEC[i][5], "R4 R5 R6 table");
    chk("R9 status set A", int'(active_bank), 1);

    // writes to unused addresses must not alter set A
    wr(4'd6, 32'hFFFF_FFFF); wr(4'd7, 32'h1234_5678); wr(4'd14, 32'hDEAD_BEEF);
    run_pix(100, 200, 300, 1'b0, 116, 150, 3795, "R7 unused addresses");

    // program set B while A runs; request B without a frame start
    prog(1'b1, 32'h0000_4000, 32'h0000_0000, 32'h2000_0000,
               32'hFF00_0000, 32'h0000_0000, 32'h0000_2000);
    wr(4'hF, 32'd2);
    run_pix(100, 200, 300, 1'b0, 116, 150, 3795, "R11 pending set not applied");
    chk("R9 status still A", int'(active_bank), 1);
    run_pix(4095, 100, 77, 1'b1, 4095, 0, 77, "R9 R6 set B on frame start");
    chk("R9 status set B", int'(active_bank), 2);
    run_pix(1000, 300, 5, 1'b0, 2000, 44, 5, "R4 set B");

    // reserved mode value ignored
    wr(4'hF, 32'd3);
    run_pix(1000, 300, 5, 1'b1, 2000, 44, 5, "R8 reserved mode ignored");
    chk("R8 status after reserved write", int'(active_bank), 2);

    // ping-pong back to A, now loaded with identity
    prog(1'b0, 32'h0000_2000, 32'h0000_0000, 32'h2000_0000,
               32'h0000_0000, 32'h0000_0000, 32'h0000_2000);
    run_pix(1000, 300, 5, 1'b0, 2000, 44, 5, "R11 rewrite inactive set");
    wr(4'hF, 32'd1);
    run_pix(0, 0, 0, 1'b1, 0, 0, 0, "R10 identity zero");
    chk("R9 status back to A", int'(active_bank), 1);
    run_pix(4095, 4095, 4095, 1'b0, 4095, 4095, 4095, "R10 identity full");
    run_pix(1234, 2345, 3456, 1'b0, 1234, 2345, 3456, "R10 identity mid");

    // back to bypass
    wr(4'hF, 32'd0);
    run_pix(7, 4095, 2048, 1'b1, 7, 4095, 2048, "R2 bypass again");
    chk("R2 status bypass", int'(active_bank), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule